// File: doc/BRIEF.md
# Tri-Port Latched Bus Exchanger

This block moves 12-bit words between one processor-facing port (A) and two memory-facing ports: B1 for the even bank or path, and B2 for the odd bank or path. Data can flow from A to either B port or to both. Data can flow back to A from either B port. There is no direct path between B1 and B2.

Each of the four directions has its own storage element:

| Storage | Direction | Enable (active high) |
|---|---|---|
| fwd1 | A to B1 | `ld_a2b1` |
| fwd2 | A to B2 | `ld_a2b2` |
| ret1 | B1 to A | `ld_b12a` |
| ret2 | B2 to A | `ld_b22a` |

Each element is transparent while its enable is high. It keeps the captured word while its enable is low. A select line chooses which return element drives A.

Each port has its own active-low output enable. Software can therefore read one B port while the other is being written. The core has no bidirectional pins, so each port is split into an input bus, an output bus and a drive flag. A parameter selects the storage form: level-sensitive latches, or edge registers with a transparent bypass for clocked fabrics. Both forms give the same port values at every clock edge, provided a data input is held steady while its enable falls.

The block has no control sequence, so it has no state machine. Its only state is the four stored words. Reset clears all four stored words. Reset also forces the three drive flags low.

Top module: `tri_port_exchanger`

## Requirements
- R1: While `rst_n` is low, all three drive flags are 0 and `a_out`, `b1_out` and `b2_out` are 0. After reset is released, the outputs stay 0 until an enable is raised.
- R2: While `ld_a2b1` is high, `b1_out` equals `a_in`.
- R3: While `ld_a2b2` is high, `b2_out` equals `a_in`.
- R4: After an enable falls, its storage output keeps the word present at the fall. Later changes on that element's data input have no effect on the output until the enable rises again.
- R5: When `sel_b1` is 1, `a_out` shows the ret1 word (B1 to A). When `sel_b1` is 0, `a_out` shows the ret2 word (B2 to A).
- R6: While `ld_b12a` is high, the ret1 word follows `b1_in`. While `ld_b22a` is high, the ret2 word follows `b2_in`.
- R7: Outside reset, `a_drv` is the inverse of `oe_a_n`, `b1_drv` is the inverse of `oe_b1_n`, and `b2_drv` is the inverse of `oe_b2_n`. The three flags are independent, and any combination of them, including all three, can be active at once.
- R8: `b1_in` never affects `b2_out`, and `b2_in` never affects `b1_out`.
- R9: The level-latch form and the clocked form give identical outputs at every sampling point, provided data is held steady while its enable falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock used by the clocked storage form and by the checker |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 12 | Word arriving on the processor-side port |
| b1_in | input | 12 | Word arriving on the even-bank port |
| b2_in | input | 12 | Word arriving on the odd-bank port |
| ld_a2b1 | input | 1 | Transparency enable for fwd1 (A to B1) |
| ld_a2b2 | input | 1 | Transparency enable for fwd2 (A to B2) |
| ld_b12a | input | 1 | Transparency enable for ret1 (B1 to A) |
| ld_b22a | input | 1 | Transparency enable for ret2 (B2 to A) |
| sel_b1 | input | 1 | 1 selects ret1 onto A, 0 selects ret2 |
| oe_a_n | input | 1 | Active-low drive enable for port A |
| oe_b1_n | input | 1 | Active-low drive enable for port B1 |
| oe_b2_n | input | 1 | Active-low drive enable for port B2 |
| a_out | output | 12 | Word driven toward the processor |
| a_drv | output | 1 | Port A drives when 1, released when 0 |
| b1_out | output | 12 | Word driven toward the even bank |
| b1_drv | output | 1 | Port B1 drives when 1 |
| b2_out | output | 12 | Word driven toward the odd bank |
| b2_drv | output | 1 | Port B2 drives when 1 |

## Verification
A wrong stored word stays invisible while its element is transparent. It appears on the port output at the first sampling point after the enable has fallen. A missed capture surfaces in the same cycle that the data input changes after the fall.

A wrong select or a crossed return path shows on `a_out` in the same cycle the select or the enables change. A second instance built in the other storage form is compared output by output on every cycle. Any divergence between the two forms is therefore reported in the cycle it occurs.

// File: rtl/bx_pkg.sv
package bx_pkg;
    typedef enum logic {
        FORM_LEVEL   = 1'b0,
        FORM_CLOCKED = 1'b1
    } store_form_e;

    localparam int PORT_A  = 0;
    localparam int PORT_B1 = 1;
    localparam int PORT_B2 = 2;
    localparam int NPORTS  = 3;
endpackage

// File: rtl/bx_store.sv
module bx_store #(
    parameter int                  WIDTH = 12,
    parameter bx_pkg::store_form_e FORM  = bx_pkg::FORM_CLOCKED
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] held;

    generate
        if (FORM == bx_pkg::FORM_LEVEL) begin : g_level
            always_latch begin
                if (!rst_n)
                    held <= '0;
                else if (en)
                    held <= d;
            end
            assign q = held;
        end else begin : g_clocked
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    held <= '0;
                else if (en)
                    held <= d;
            end
            // bypass gives transparency between edges
            assign q = (en && rst_n) ? d : held;
        end
    endgenerate
endmodule

// File: rtl/bx_return_mux.sv
module bx_return_mux #(
    parameter int WIDTH = 12
) (
    input  logic             sel_first,
    input  logic [WIDTH-1:0] first,
    input  logic [WIDTH-1:0] second,
    output logic [WIDTH-1:0] y
);
    always_comb begin
        unique case (sel_first)
            1'b1:    y = first;
            default: y = second;
        endcase
    end
endmodule

// File: rtl/bx_port_enable.sv
module bx_port_enable #(
    parameter int N = bx_pkg::NPORTS
) (
    input  logic         rst_n,
    input  logic [N-1:0] oe_n,
    output logic [N-1:0] drv
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_port
            assign drv[i] = rst_n & ~oe_n[i];
        end
    endgenerate
endmodule

// File: rtl/tri_port_exchanger.sv
module tri_port_exchanger #(
    parameter int                  WIDTH = 12,
    parameter bx_pkg::store_form_e FORM  = bx_pkg::FORM_CLOCKED
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b1_in,
    input  logic [WIDTH-1:0] b2_in,
    input  logic             ld_a2b1,
    input  logic             ld_a2b2,
    input  logic             ld_b12a,
    input  logic             ld_b22a,
    input  logic             sel_b1,
    input  logic             oe_a_n,
    input  logic             oe_b1_n,
    input  logic             oe_b2_n,
    output logic [WIDTH-1:0] a_out,
    output logic             a_drv,
    output logic [WIDTH-1:0] b1_out,
    output logic             b1_drv,
    output logic [WIDTH-1:0] b2_out,
    output logic             b2_drv
);
    localparam int NP = bx_pkg::NPORTS;

    logic [WIDTH-1:0] ret1_q, ret2_q;
    logic [NP-1:0]    oe_vec_n, drv_vec;

    bx_store #(.WIDTH(WIDTH), .FORM(FORM)) u_fwd1 (
        .clk(clk), .rst_n(rst_n), .en(ld_a2b1), .d(a_in), .q(b1_out));
    bx_store #(.WIDTH(WIDTH), .FORM(FORM)) u_fwd2 (
        .clk(clk), .rst_n(rst_n), .en(ld_a2b2), .d(a_in), .q(b2_out));
    bx_store #(.WIDTH(WIDTH), .FORM(FORM)) u_ret1 (
        .clk(clk), .rst_n(rst_n), .en(ld_b12a), .d(b1_in), .q(ret1_q));
    bx_store #(.WIDTH(WIDTH), .FORM(FORM)) u_ret2 (
        .clk(clk), .rst_n(rst_n), .en(ld_b22a), .d(b2_in), .q(ret2_q));

    bx_return_mux #(.WIDTH(WIDTH)) u_mux (
        .sel_first(sel_b1), .first(ret1_q), .second(ret2_q), .y(a_out));

    always_comb begin
        oe_vec_n                  = '1;
        oe_vec_n[bx_pkg::PORT_A]  = oe_a_n;
        oe_vec_n[bx_pkg::PORT_B1] = oe_b1_n;
        oe_vec_n[bx_pkg::PORT_B2] = oe_b2_n;
    end

    bx_port_enable #(.N(NP)) u_oe (
        .rst_n(rst_n), .oe_n(oe_vec_n), .drv(drv_vec));

    assign a_drv  = drv_vec[bx_pkg::PORT_A];
    assign b1_drv = drv_vec[bx_pkg::PORT_B1];
    assign b2_drv = drv_vec[bx_pkg::PORT_B2];
endmodule

// File: rtl/bx_checker.sv
module bx_checker #(
    parameter int WIDTH = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] b1_in,
    input logic [WIDTH-1:0] b2_in,
    input logic             ld_a2b1,
    input logic             ld_a2b2,
    input logic             ld_b12a,
    input logic             ld_b22a,
    input logic             sel_b1,
    input logic             oe_a_n,
    input logic             oe_b1_n,
    input logic             oe_b2_n,
    input logic [WIDTH-1:0] a_out,
    input logic             a_drv,
    input logic [WIDTH-1:0] b1_out,
    input logic             b1_drv,
    input logic [WIDTH-1:0] b2_out,
    input logic             b2_drv
);
    always @(posedge clk) begin
        if (rst_n === 1'b0) begin
            p_reset_quiet_r1: assert (!a_drv && !b1_drv && !b2_drv && b1_out == '0 && b2_out == '0);
        end
    end

    p_fwd1_transp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_a2b1 |-> b1_out == a_in);

    p_fwd2_transp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ld_a2b2 |-> b2_out == a_in);

    p_fwd1_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_a2b1 && $past(!ld_a2b1)) |-> $stable(b1_out));

    p_fwd2_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_a2b2 && $past(!ld_a2b2)) |-> $stable(b2_out));

    p_sel_b1_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_b1 && ld_b12a) |-> a_out == b1_in);

    p_sel_b2_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_b1 && ld_b22a) |-> a_out == b2_in);

    p_drive_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (a_drv != oe_a_n) && (b1_drv != oe_b1_n) && (b2_drv != oe_b2_n));
endmodule

bind tri_port_exchanger bx_checker #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b1_in(b1_in), .b2_in(b2_in),
    .ld_a2b1(ld_a2b1), .ld_a2b2(ld_a2b2), .ld_b12a(ld_b12a), .ld_b22a(ld_b22a),
    .sel_b1(sel_b1), .oe_a_n(oe_a_n), .oe_b1_n(oe_b1_n), .oe_b2_n(oe_b2_n),
    .a_out(a_out), .a_drv(a_drv), .b1_out(b1_out), .b1_drv(b1_drv),
    .b2_out(b2_out), .b2_drv(b2_drv));

// File: tb/tri_port_exchanger_tb_top.sv
module tri_port_exchanger_tb_top;
    localparam int W = 12;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic         rst_n;
    logic [W-1:0] a_in, b1_in, b2_in;
    logic         ld_a2b1, ld_a2b2, ld_b12a, ld_b22a, sel_b1;
    logic         oe_a_n, oe_b1_n, oe_b2_n;

    logic [W-1:0] a_out, b1_out, b2_out, l_a_out, l_b1_out, l_b2_out;
    logic         a_drv, b1_drv, b2_drv, l_a_drv, l_b1_drv, l_b2_drv;

    int n_chk = 0;
    int n_err = 0;

    logic [W-1:0] m_f1, m_f2, m_r1, m_r2;

    tri_port_exchanger #(.WIDTH(W), .FORM(bx_pkg::FORM_CLOCKED)) dut_i (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b1_in(b1_in), .b2_in(b2_in),
        .ld_a2b1(ld_a2b1), .ld_a2b2(ld_a2b2), .ld_b12a(ld_b12a), .ld_b22a(ld_b22a),
        .sel_b1(sel_b1), .oe_a_n(oe_a_n), .oe_b1_n(oe_b1_n), .oe_b2_n(oe_b2_n),
        .a_out(a_out), .a_drv(a_drv), .b1_out(b1_out), .b1_drv(b1_drv),
        .b2_out(b2_out), .b2_drv(b2_drv));

    tri_port_exchanger #(.WIDTH(W), .FORM(bx_pkg::FORM_LEVEL)) dut_lvl_i (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b1_in(b1_in), .b2_in(b2_in),
        .ld_a2b1(ld_a2b1), .ld_a2b2(ld_a2b2), .ld_b12a(ld_b12a), .ld_b22a(ld_b22a),
        .sel_b1(sel_b1), .oe_a_n(oe_a_n), .oe_b1_n(oe_b1_n), .oe_b2_n(oe_b2_n),
        .a_out(l_a_out), .a_drv(l_a_drv), .b1_out(l_b1_out), .b1_drv(l_b1_drv),
        .b2_out(l_b2_out), .b2_drv(l_b2_drv));

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] exp_a();
        return sel_b1 ? m_r1 : m_r2;
    endfunction

    function automatic logic [W-1:0] exp_drv();
        return {{(W-3){1'b0}}, ~oe_b2_n, ~oe_b1_n, ~oe_a_n};
    endfunction

    task automatic check_all();
        chk("R2 fwd1 word on b1_out", b1_out, m_f1);
        chk("R3 fwd2 word on b2_out", b2_out, m_f2);
        chk("R5/R6 selected return word on a_out", a_out, exp_a());
        chk("R7 drive flags", {{(W-3){1'b0}}, b2_drv, b1_drv, a_drv}, exp_drv());
        chk("R9 a_out form match", l_a_out, a_out);
        chk("R9 b1_out form match", l_b1_out, b1_out);
        chk("R9 b2_out form match", l_b2_out, b2_out);
        chk("R9 drive form match", {{(W-3){1'b0}}, l_b2_drv, l_b1_drv, l_a_drv},
            {{(W-3){1'b0}}, b2_drv, b1_drv, a_drv});
    endtask

    // ld bits: [0] A->B1, [1] A->B2, [2] B1->A, [3] B2->A; oe bits: [0] A, [1] B1, [2] B2
    task automatic step(input logic [W-1:0] a, input logic [W-1:0] b1, input logic [W-1:0] b2,
                        input logic [3:0] ld, input logic sel, input logic [2:0] oen);
        @(negedge clk);
        if ((ld_a2b1 && !ld[0]) || (ld_a2b2 && !ld[1])) a = a_in;
        if (ld_b12a && !ld[2]) b1 = b1_in;
        if (ld_b22a && !ld[3]) b2 = b2_in;
        a_in = a; b1_in = b1; b2_in = b2;
        {ld_b22a, ld_b12a, ld_a2b2, ld_a2b1} = ld;
        sel_b1 = sel;
        {oe_b2_n, oe_b1_n, oe_a_n} = oen;
        if (ld[0]) m_f1 = a;
        if (ld[1]) m_f2 = a;
        if (ld[2]) m_r1 = b1;
        if (ld[3]) m_r2 = b2;
        #4;
        check_all();
    endtask

    initial begin
        #2_000_000;
        n_err++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        m_f1 = '0; m_f2 = '0; m_r1 = '0; m_r2 = '0;
        rst_n = 1'b0;
        a_in = 12'hA5A; b1_in = 12'h3C3; b2_in = 12'h0F0;
        {ld_a2b1, ld_a2b2, ld_b12a, ld_b22a} = 4'hF;
        sel_b1 = 1'b1;
        {oe_a_n, oe_b1_n, oe_b2_n} = 3'b000;
        repeat (3) @(negedge clk);
        #4;
        chk("R1 reset a_out", a_out, '0);
        chk("R1 reset b1_out", b1_out, '0);
        chk("R1 reset b2_out", b2_out, '0);
        chk("R1 reset drive flags", {{(W-3){1'b0}}, b2_drv, b1_drv, a_drv}, '0);
        @(negedge clk);
        {ld_a2b1, ld_a2b2, ld_b12a, ld_b22a} = 4'h0;
        @(negedge clk);
        rst_n = 1'b1;
        #4;
        chk("R1 post-reset b1_out", b1_out, '0);
        chk("R1 post-reset a_out", a_out, '0);

        // R4 capture and hold on A->B1
        step(12'hABC, 12'h000, 12'h000, 4'b0001, 1'b1, 3'b111);
        step(12'hABC, 12'h000, 12'h000, 4'b0000, 1'b1, 3'b111);
        step(12'h123, 12'h000, 12'h000, 4'b0000, 1'b1, 3'b111);
        chk("R4 held fwd1 word", b1_out, 12'hABC);

        // R8 isolation: B1 activity does not reach B2 or the ret2 path
        step(12'h123, 12'h777, 12'h000, 4'b0100, 1'b0, 3'b000);
        step(12'h123, 12'h888, 12'h000, 4'b0100, 1'b0, 3'b000);
        chk("R8 b2_out untouched by b1_in", b2_out, 12'h000);
        chk("R8 a_out via ret2 untouched by b1_in", a_out, 12'h000);
        step(12'h123, 12'h888, 12'h000, 4'b0100, 1'b1, 3'b000);
        chk("R5 a_out from ret1", a_out, 12'h888);

        // walk every enable / select / output-enable combination
        for (int c = 0; c < 256; c++) begin
            step(W'($urandom), W'($urandom), W'($urandom), c[3:0], c[4], c[7:5]);
        end

        // constrained random: enables mostly low to exercise holding
        for (int i = 0; i < 400; i++) begin
            logic [3:0] ld;
            ld = 4'($urandom) & 4'($urandom);
            step(W'($urandom), W'($urandom), W'($urandom), ld, 1'($urandom), 3'($urandom));
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule